// File: doc/BRIEF.md
# Key-Protected Low-Speed Clock Selector

This block chooses the low-speed timekeeping reference for a real-time clock domain. Two free-running sources arrive as raw levels: a fast internal RC oscillator and an external 32 kHz crystal. The RC path is brought into the system clock domain, divided by a fixed build-time factor, and then divided again by a programmable count of P+1. The crystal path is brought into the system clock domain and used undivided. Whichever source is selected produces a single-cycle `tick` enable that the rest of the timekeeping logic counts.

Software configures the block through a small 32-bit register interface. The control register accepts a write only when the upper half of the written word carries a 16-bit unlock key. This keeps a stray store from switching the time base. The prescaler register and the output-gate register accept plain writes. A registered, gated copy of the selected low-speed level is provided for an output pin. The control register also drives the enable for the external oscillator and the flag that disables automatic fallback to the RC source.

Top module: `lsclk_select`

## Requirements
- R1: A write to offset 0x00 updates the control state only when wr_data[31:16] equals 0x16AA. Any other value in that field, including 0x16AB, leaves the control state unchanged.
- R2: A read of offset 0x00 returns zero in bits [31:16] and in every bit except the three stored fields: bit 0 (source select), bit 4 (external oscillator enable) and bit 15 (fallback bypass).
- R3: Control bit 0 selects the tick source (0 = divided RC path, 1 = crystal). Output `xosc_en` follows stored bit 4, and output `fallback_byp` follows stored bit 15.
- R4: Offset 0x08 holds the 5-bit divide value P in bits [4:0]. It is written without a key, and upper data bits are discarded, so reads return zero above bit 4.
- R5: With the RC source selected, consecutive ticks are RC_period × FIX_DIV × (P+1) system cycles apart (FIX_DIV defaults to 32). This holds for P = 0, for an intermediate P, and for P = 31.
- R6: With the crystal selected, one tick is produced for each crystal rising edge, so the tick spacing equals the crystal period.
- R7: `tick` is never high for two consecutive system cycles.
- R8: Offset 0x60 bit 0 enables `lsclk_out`. While it is 0, `lsclk_out` stays low. While it is 1, `lsclk_out` follows the selected low-speed level.
- R9: After reset, the control fields, P and the gate enable are all zero: the RC source is selected, and all three registers read back 0.
- R10: Offsets other than 0x00, 0x08 and 0x60 read as zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Write byte offset |
| wr_data | input | 32 | Write data |
| rd_addr | input | 8 | Read byte offset |
| rd_data | output | 32 | Read data (combinational) |
| rc_osc | input | 1 | Raw internal RC oscillator level |
| xtal_osc | input | 1 | Raw external crystal level |
| tick | output | 1 | One-cycle enable per low-speed period |
| lsclk_out | output | 1 | Gated copy of the selected low-speed level |
| xosc_en | output | 1 | External oscillator enable from control bit 4 |
| fallback_byp | output | 1 | Fallback bypass from control bit 15 |

## Verification
A register write takes effect at the capturing clock edge, and readback is combinational. The bench therefore drives each write for one cycle and then samples `rd_data` on the following low clock phase. The tick results come through a two-flop synchronizer, an edge register and the tick register, so a fixed latency follows each source edge. Rather than rely on that latency, the bench compares the spacing between successive ticks with the expected period. It discards the first interval after any configuration change, because the divider counters are then in mid-count. `lsclk_out` is registered one cycle after the gate enable, so the gated and ungated checks sample over a window that begins after the enabling write has settled.

// File: rtl/lsclk_pkg.sv
package lsclk_pkg;

    localparam logic [15:0] UNLOCK_KEY = 16'h16AA;

    localparam int          OFS_W    = 8;
    localparam logic [7:0]  OFS_CTRL = 8'h00;
    localparam logic [7:0]  OFS_DIV  = 8'h08;
    localparam logic [7:0]  OFS_GATE = 8'h60;

    localparam int SEL_POS = 0;
    localparam int XEN_POS = 4;
    localparam int BYP_POS = 15;

    typedef enum logic {
        SRC_RC   = 1'b0,
        SRC_XTAL = 1'b1
    } src_e;

    typedef struct packed {
        logic bypass;
        logic xosc_on;
        src_e src;
    } ctrl_t;

    function automatic logic key_match(input logic [31:0] d);
        return d[31:16] == UNLOCK_KEY;
    endfunction

    function automatic ctrl_t ctrl_unpack(input logic [31:0] d);
        ctrl_t c;
        c.bypass  = d[BYP_POS];
        c.xosc_on = d[XEN_POS];
        c.src     = src_e'(d[SEL_POS]);
        return c;
    endfunction

    function automatic logic [31:0] ctrl_pack(input ctrl_t c);
        logic [31:0] w;
        w          = '0;
        w[BYP_POS] = c.bypass;
        w[XEN_POS] = c.xosc_on;
        w[SEL_POS] = c.src;
        return w;
    endfunction

endpackage

// File: rtl/lsclk_regs.sv
module lsclk_regs
    import lsclk_pkg::*;
#(
    parameter int DIV_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [OFS_W-1:0]  wr_addr,
    input  logic [31:0]       wr_data,
    input  logic [OFS_W-1:0]  rd_addr,
    output logic [31:0]       rd_data,
    output ctrl_t             ctrl,
    output logic [DIV_W-1:0]  div_sel,
    output logic              gate_en
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl    <= '0;
            div_sel <= '0;
            gate_en <= 1'b0;
        end else if (wr_en) begin
            unique case (wr_addr)
                OFS_CTRL: if (key_match(wr_data)) ctrl <= ctrl_unpack(wr_data);
                OFS_DIV:  div_sel <= wr_data[DIV_W-1:0];
                OFS_GATE: gate_en <= wr_data[0];
                default:  ;
            endcase
        end
    end

    always_comb begin
        unique case (rd_addr)
            OFS_CTRL: rd_data = ctrl_pack(ctrl);
            OFS_DIV:  rd_data = {{(32-DIV_W){1'b0}}, div_sel};
            OFS_GATE: rd_data = {31'b0, gate_en};
            default:  rd_data = '0;
        endcase
    end

endmodule

// File: rtl/lsclk_edge_sync.sv
module lsclk_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic lvl,
    output logic rise
);

    logic [STAGES-1:0] chain;
    logic              prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
            prev  <= 1'b0;
        end else begin
            chain <= {chain[STAGES-2:0], din};
            prev  <= chain[STAGES-1];
        end
    end

    assign lvl  = chain[STAGES-1];
    assign rise = chain[STAGES-1] & ~prev;

endmodule

// File: rtl/lsclk_int_div.sv
module lsclk_int_div #(
    parameter int FIX_DIV = 32,
    parameter int DIV_W   = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rc_rise,
    input  logic [DIV_W-1:0] div_sel,
    output logic             wrap,
    output logic             lvl
);

    localparam int CNT_W = (FIX_DIV > 2) ? $clog2(FIX_DIV) : 1;
    localparam logic [CNT_W-1:0] FIX_LAST = CNT_W'(FIX_DIV - 1);
    localparam logic [CNT_W-1:0] FIX_HALF = CNT_W'(FIX_DIV / 2 - 1);

    logic [CNT_W-1:0] fix_cnt;
    logic [DIV_W-1:0] pre_cnt;
    logic             fix_last;
    logic             pre_last;

    assign fix_last = (fix_cnt == FIX_LAST);
    assign pre_last = (pre_cnt >= div_sel);
    assign wrap     = rc_rise & fix_last & pre_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            fix_cnt <= '0;
            pre_cnt <= '0;
            lvl     <= 1'b0;
        end else if (rc_rise) begin
            fix_cnt <= fix_last ? '0 : fix_cnt + 1'b1;
            if (fix_last) pre_cnt <= pre_last ? '0 : pre_cnt + 1'b1;
            if (wrap)
                lvl <= 1'b1;
            else if (fix_cnt == FIX_HALF)
                lvl <= 1'b0;
        end
    end

endmodule

// File: rtl/lsclk_select.sv
module lsclk_select
    import lsclk_pkg::*;
#(
    parameter int FIX_DIV     = 32,
    parameter int DIV_W       = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [7:0]  wr_addr,
    input  logic [31:0] wr_data,
    input  logic [7:0]  rd_addr,
    output logic [31:0] rd_data,
    input  logic        rc_osc,
    input  logic        xtal_osc,
    output logic        tick,
    output logic        lsclk_out,
    output logic        xosc_en,
    output logic        fallback_byp
);

    localparam int NSRC = 2;

    ctrl_t            ctrl;
    logic [DIV_W-1:0] div_sel;
    logic             gate_en;
    logic [NSRC-1:0]  raw_in;
    logic [NSRC-1:0]  s_lvl;
    logic [NSRC-1:0]  s_rise;
    logic             int_wrap;
    logic             int_lvl;
    logic             sel_tick;
    logic             sel_lvl;

    lsclk_regs #(.DIV_W(DIV_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .ctrl    (ctrl),
        .div_sel (div_sel),
        .gate_en (gate_en)
    );

    assign raw_in[SRC_RC]   = rc_osc;
    assign raw_in[SRC_XTAL] = xtal_osc;

    for (genvar g = 0; g < NSRC; g++) begin : g_sync
        lsclk_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk  (clk),
            .rst  (rst),
            .din  (raw_in[g]),
            .lvl  (s_lvl[g]),
            .rise (s_rise[g])
        );
    end

    lsclk_int_div #(.FIX_DIV(FIX_DIV), .DIV_W(DIV_W)) u_div (
        .clk     (clk),
        .rst     (rst),
        .rc_rise (s_rise[SRC_RC]),
        .div_sel (div_sel),
        .wrap    (int_wrap),
        .lvl     (int_lvl)
    );

    always_comb begin
        if (ctrl.src == SRC_XTAL) begin
            sel_tick = s_rise[SRC_XTAL];
            sel_lvl  = s_lvl[SRC_XTAL];
        end else begin
            sel_tick = int_wrap;
            sel_lvl  = int_lvl;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tick      <= 1'b0;
            lsclk_out <= 1'b0;
        end else begin
            tick      <= sel_tick;
            lsclk_out <= gate_en & sel_lvl;
        end
    end

    assign xosc_en      = ctrl.xosc_on;
    assign fallback_byp = ctrl.bypass;

endmodule

// File: rtl/lsclk_select_chk.sv
module lsclk_select_chk
    import lsclk_pkg::*;
#(
    parameter int DIV_W = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic [7:0]       wr_addr,
    input logic [31:0]      wr_data,
    input logic [7:0]       rd_addr,
    input logic [31:0]      rd_data,
    input logic             tick,
    input logic             lsclk_out,
    input ctrl_t            ctrl,
    input logic [DIV_W-1:0] div_sel,
    input logic             gate_en
);

    assert_key_guard_R1: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == OFS_CTRL && wr_data[31:16] != UNLOCK_KEY) |=> $stable(ctrl));

    assert_ctrl_read_R2: assert property (@(posedge clk) disable iff (rst)
        (rd_addr == OFS_CTRL) |-> (rd_data[31:16] == 16'h0));

    assert_div_write_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == OFS_DIV) |=> (div_sel == $past(wr_data[DIV_W-1:0])));

    assert_tick_single_R7: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);

    assert_gate_off_R8: assert property (@(posedge clk) disable iff (rst)
        !gate_en |=> !lsclk_out);

    assert_reset_state_R9: assert property (@(posedge clk)
        rst |=> (ctrl == '0 && div_sel == '0 && !gate_en && !tick));

endmodule

bind lsclk_select lsclk_select_chk #(.DIV_W(DIV_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .tick      (tick),
    .lsclk_out (lsclk_out),
    .ctrl      (ctrl),
    .div_sel   (div_sel),
    .gate_en   (gate_en)
);

// File: tb/lsclk_select_bench.sv
module lsclk_select_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [7:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        rc_osc = 1'b0;
    logic        xtal_osc = 1'b0;
    logic        tick;
    logic        lsclk_out;
    logic        xosc_en;
    logic        fallback_byp;

    int total = 0;
    int fails = 0;
    int cyc   = 0;

    always #4 clk = ~clk;
    initial begin #1; forever #32 rc_osc = ~rc_osc; end
    initial begin #2; forever #48 xtal_osc = ~xtal_osc; end

    lsclk_select u_lsclk_select (
        .clk          (clk),
        .rst          (rst),
        .wr_en        (wr_en),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .rd_addr      (rd_addr),
        .rd_data      (rd_data),
        .rc_osc       (rc_osc),
        .xtal_osc     (xtal_osc),
        .tick         (tick),
        .lsclk_out    (lsclk_out),
        .xosc_en      (xosc_en),
        .fallback_byp (fallback_byp)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            total++;
            fails++;
            $display("FAIL watchdog: run did not finish, got cycle %0d expected < 150000", cyc);
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic get_period(output int per, output bit single);
        int t0;
        single = 1'b1;
        @(negedge clk);
        while (!tick) @(negedge clk);
        t0 = cyc;
        @(negedge clk);
        if (tick) single = 1'b0;
        while (!tick) @(negedge clk);
        per = cyc - t0;
    endtask

    // {we, addr, wdata, expected readback of addr}
    localparam int NVEC = 11;
    localparam logic [72:0] VEC [NVEC] = '{
        {1'b1, 8'h00, 32'h16AA_8011, 32'h0000_8011},
        {1'b1, 8'h00, 32'h1234_0000, 32'h0000_8011},
        {1'b1, 8'h00, 32'h16AA_FFFF, 32'h0000_8011},
        {1'b1, 8'h00, 32'h16AA_0000, 32'h0000_0000},
        {1'b1, 8'h00, 32'h16AB_0001, 32'h0000_0000},
        {1'b1, 8'h08, 32'h0000_001F, 32'h0000_001F},
        {1'b1, 8'h08, 32'hFFFF_FFE5, 32'h0000_0005},
        {1'b1, 8'h60, 32'h0000_0001, 32'h0000_0001},
        {1'b1, 8'h60, 32'h0000_0000, 32'h0000_0000},
        {1'b1, 8'h04, 32'hFFFF_FFFF, 32'h0000_0000},
        {1'b0, 8'h08, 32'h0000_0000, 32'h0000_0005}
    };

    initial begin
        logic [31:0] v;
        int          per;
        bit          single;
        int          rises;
        int          highs;
        logic        last;

        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R9: reset state
        rd(8'h00, v); check("R9 ctrl after reset", v, 32'h0);
        rd(8'h08, v); check("R9 divider after reset", v, 32'h0);
        rd(8'h60, v); check("R9 gate after reset", v, 32'h0);
        check("R9 lsclk_out after reset", {31'b0, lsclk_out}, 32'h0);

        // R1, R2, R4, R10: register vectors
        for (int i = 0; i < NVEC; i++) begin
            if (VEC[i][72]) wr(VEC[i][71:64], VEC[i][63:32]);
            @(negedge clk);
            rd(VEC[i][71:64], v);
            check($sformatf("R1/R2/R4/R10 register vector %0d", i), v, VEC[i][31:0]);
        end

        // R3: side outputs follow stored bits
        wr(8'h00, 32'h16AA_8010);
        check("R3 xosc_en from bit 4", {31'b0, xosc_en}, 32'h1);
        check("R3 fallback_byp from bit 15", {31'b0, fallback_byp}, 32'h1);
        wr(8'h00, 32'h5555_0000);
        check("R1 bad key keeps xosc_en", {31'b0, xosc_en}, 32'h1);

        // R5: internal path periods (RC period 8 cycles, FIX_DIV 32)
        wr(8'h00, 32'h16AA_0000);
        wr(8'h08, 32'h0);
        get_period(per, single);
        get_period(per, single);
        check("R5 internal period P=0", per, 32'd256);
        check("R7 tick width P=0", {31'b0, single}, 32'h1);
        wr(8'h08, 32'h3);
        get_period(per, single);
        get_period(per, single);
        check("R5 internal period P=3", per, 32'd1024);
        wr(8'h08, 32'h1F);
        get_period(per, single);
        get_period(per, single);
        check("R5 internal period P=31", per, 32'd8192);

        // R6: crystal path undivided (crystal period 12 cycles), R3 select
        wr(8'h00, 32'h16AA_0011);
        get_period(per, single);
        get_period(per, single);
        check("R6 crystal tick period", per, 32'd12);
        check("R7 tick width crystal", {31'b0, single}, 32'h1);

        // R8: gate on then off
        wr(8'h60, 32'h1);
        repeat (4) @(negedge clk);
        rises = 0; last = lsclk_out;
        for (int k = 0; k < 48; k++) begin
            @(negedge clk);
            if (lsclk_out && !last) rises++;
            last = lsclk_out;
        end
        check("R8 gated output toggles with crystal", rises, 32'd4);
        wr(8'h60, 32'h0);
        @(negedge clk);
        highs = 0;
        for (int k = 0; k < 48; k++) begin
            @(negedge clk);
            if (lsclk_out) highs++;
        end
        check("R8 gated output held low when off", highs, 32'd0);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule